// File: doc/BRIEF.md
# Queue-Driven Memory Bank Power Controller

This block sits between a packet source and a single packet server. Behind it lies a packet buffer split into equal banks, and each bank has its own power switch. A packet shows up on a valid/ready port with a byte count. If the queue is empty and the server can take work in that cycle, the packet goes straight through to the server port and uses no buffer space. In every other case the packet is queued in arrival order. Before that, the controller makes sure that enough banks are switched on to hold the total of all queued bytes.

Each bank's power enable follows how much of the buffer is in use. A bank comes on one cycle before data may be written into it. It goes off one cycle after the server has drained the last bytes that needed it. An arrival that finds the queue full, or finds too little room left in the buffer, is accepted and thrown away, and a drop counter records it. An energy accumulator charges three kinds of event, each at a programmable cost: receiving a packet, storing a packet (charged once per bank in use after the store), and handing a packet to the server. The accumulator saturates at its maximum value instead of wrapping.

Top module: `mem_bank_pwr_ctrl`

## Requirements
- R1: When `in_valid_i` and `srv_ready_i` are high and the queue is empty, the packet is accepted and shown on the server port in the same cycle: `srv_valid_o`=1 and `srv_size_o`=`in_size_i`. It is not queued, and no bank is switched on for it.
- R2: An arrival that finds the server not ready or the queue non-empty is queued. Queued packets reach the server port in arrival order, and the queue head is shown on `srv_valid_o`/`srv_size_o` whenever the queue is non-empty.
- R3: Banks in use equal the ceiling of the queued bytes divided by `BANK_BYTES`, with a minimum of 1 while the queue is non-empty and 0 when it is empty. `bank_en_o` is a thermometer code starting at bit 0, and `bank_on_cnt_o` gives the number of its set bits.
- R4: An arrival that needs more banks than are currently powered sees `in_ready_o` low for that cycle. The extra banks are on after the next edge, and the packet is accepted no earlier than the following cycle.
- R5: When dequeues lower the number of banks in use, the surplus enables drop one cycle after the dequeue edge, not on that edge itself.
- R6: An arrival that is not bypassed, and that finds `QUEUE_DEPTH` packets queued or would push the queued bytes above `NUM_BANKS*BANK_BYTES`, sees `in_ready_o` high. It is discarded, `drop_cnt_o` rises by one, and the queue and the banks are left unchanged.
- R7: In every cycle `energy_o` grows by the sum of three terms. The first is `cost_arr_i` for each accepted arrival, including dropped ones. The second is `cost_queue_i` times the banks in use after a store, for each packet stored. The third is `cost_srv_i` for each packet handed to the server, whether bypassed or dequeued.
- R8: `energy_o` saturates at all ones and never wraps.
- R9: After reset the queue is empty, all banks are off, and the drop and energy counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Arriving packet valid |
| in_ready_o | output | 1 | Arrival accepted (bypassed, queued or dropped) |
| in_size_i | input | SIZE_W | Arriving packet size in bytes (at least 1) |
| srv_valid_o | output | 1 | Packet offered to the server |
| srv_ready_i | input | 1 | Server is idle and takes the offered packet |
| srv_size_o | output | SIZE_W | Size of the offered packet |
| cost_arr_i | input | COST_W | Energy cost of one arrival |
| cost_queue_i | input | COST_W | Energy cost of one store, per bank in use |
| cost_srv_i | input | COST_W | Energy cost of one service |
| bank_en_o | output | NUM_BANKS | Per-bank power enables |
| bank_on_cnt_o | output | $clog2(NUM_BANKS+1) | Number of banks powered |
| queue_cnt_o | output | $clog2(QUEUE_DEPTH+1) | Packets queued |
| drop_cnt_o | output | DROP_W | Dropped arrivals, saturating |
| energy_o | output | ENERGY_W | Energy accumulator, saturating |

## Verification
The bench builds the block with 4 banks of 64 bytes, a queue depth of 5, 8-bit sizes and costs, and a 12-bit energy accumulator. With 64-byte banks, packets of a few dozen bytes cross bank boundaries, so power-up stalls, the extra cycle before a bank turns off, and the byte-capacity drop all come up within a few cycles. With a depth of 5, the queue fills in a few cycles and its pointers wrap at a count that is not a power of two. With a 12-bit accumulator, saturation is reached after about five hundred bypassed packets.

// File: rtl/mem_bank_pwr_pkg.sv
package mem_bank_pwr_pkg;

  // ceil(bytes / 2**shift), forced to at least 1 while data is queued
  function automatic logic [31:0] banks_of(input logic [31:0] bytes,
                                           input logic        nonempty,
                                           input int unsigned shift);
    logic [31:0] b;
    b = (bytes + ((32'd1 << shift) - 32'd1)) >> shift;
    if (!nonempty)      b = '0;
    else if (b == '0)   b = 32'd1;
    return b;
  endfunction

endpackage

// File: rtl/mem_bank_size_fifo.sv
module mem_bank_size_fifo #(
  parameter int unsigned DEPTH = 100,
  parameter int unsigned W     = 16,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= inc(wr_q);
      if (do_pop)  rd_q <= inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/mem_bank_pwr_switch.sv
module mem_bank_pwr_switch #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BW       = $clog2(NUM_BANKS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BW-1:0]        live_cur_i,  // banks needed by registered occupancy
  input  logic [BW-1:0]        live_nxt_i,  // banks needed after this cycle's updates
  input  logic [BW-1:0]        pend_i,      // banks a stalled arrival waits for
  output logic [BW-1:0]        on_cnt_o,
  output logic [NUM_BANKS-1:0] en_o
);

  logic [BW-1:0] on_q, tgt;

  // holding live_cur keeps drained banks on for one extra cycle
  always_comb begin
    tgt = live_cur_i;
    if (live_nxt_i > tgt) tgt = live_nxt_i;
    if (pend_i > tgt)     tgt = pend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) on_q <= '0;
    else         on_q <= tgt;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
    assign en_o[b] = (on_q > BW'(b));
  end

  assign on_cnt_o = on_q;

endmodule

// File: rtl/mem_bank_energy_acc.sv
module mem_bank_energy_acc #(
  parameter int unsigned COST_W   = 16,
  parameter int unsigned ENERGY_W = 32,
  parameter int unsigned BW       = 3,
  localparam int unsigned SUM_W   = ENERGY_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arr_i,
  input  logic                enq_i,
  input  logic [BW-1:0]       enq_banks_i,
  input  logic                srv_i,
  input  logic [COST_W-1:0]   cost_arr_i,
  input  logic [COST_W-1:0]   cost_queue_i,
  input  logic [COST_W-1:0]   cost_srv_i,
  output logic [ENERGY_W-1:0] energy_o
);

  localparam logic [ENERGY_W-1:0] EMAX = {ENERGY_W{1'b1}};

  logic [ENERGY_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0]    sum;

  always_comb begin
    sum = SUM_W'(acc_q);
    if (arr_i) sum = sum + SUM_W'(cost_arr_i);
    if (enq_i) sum = sum + SUM_W'(cost_queue_i) * SUM_W'(enq_banks_i);
    if (srv_i) sum = sum + SUM_W'(cost_srv_i);
    acc_d = (sum > SUM_W'(EMAX)) ? EMAX : ENERGY_W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign energy_o = acc_q;

endmodule

// File: rtl/mem_bank_pwr_ctrl.sv
module mem_bank_pwr_ctrl
  import mem_bank_pwr_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned BANK_BYTES  = 32768,  // power of two
  parameter int unsigned QUEUE_DEPTH = 100,
  parameter int unsigned SIZE_W      = 16,
  parameter int unsigned COST_W      = 16,
  parameter int unsigned ENERGY_W    = 32,
  parameter int unsigned DROP_W      = 16,
  localparam int unsigned BW         = $clog2(NUM_BANKS + 1),
  localparam int unsigned CW         = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [SIZE_W-1:0]    in_size_i,
  output logic                 srv_valid_o,
  input  logic                 srv_ready_i,
  output logic [SIZE_W-1:0]    srv_size_o,
  input  logic [COST_W-1:0]    cost_arr_i,
  input  logic [COST_W-1:0]    cost_queue_i,
  input  logic [COST_W-1:0]    cost_srv_i,
  output logic [NUM_BANKS-1:0] bank_en_o,
  output logic [BW-1:0]        bank_on_cnt_o,
  output logic [CW-1:0]        queue_cnt_o,
  output logic [DROP_W-1:0]    drop_cnt_o,
  output logic [ENERGY_W-1:0]  energy_o
);

  localparam int unsigned CAP     = NUM_BANKS * BANK_BYTES;
  localparam int unsigned TOT_W   = $clog2(CAP + 1);
  localparam int unsigned BANK_SH = $clog2(BANK_BYTES);

  logic [TOT_W-1:0]  tot_q, tot_d;
  logic [CW-1:0]     q_cnt, cnt_d;
  logic [SIZE_W-1:0] head_size;
  logic [BW-1:0]     on_cnt, live_cur, live_nxt, pend;
  logic [DROP_W-1:0] drop_q;
  logic [31:0]       need_bytes, need_bk;
  logic q_empty, bypass_ok, bypass, over, drop, pwr_ok, enq, deq, arr;

  assign q_empty   = (q_cnt == '0);
  assign bypass_ok = srv_ready_i && q_empty;
  assign bypass    = in_valid_i && bypass_ok;

  assign need_bytes = 32'(tot_q) + 32'(in_size_i);
  assign need_bk    = banks_of(need_bytes, 1'b1, BANK_SH);
  assign over       = (q_cnt == CW'(QUEUE_DEPTH)) || (need_bytes > 32'(CAP));
  assign pwr_ok     = (32'(on_cnt) >= need_bk);

  assign drop = in_valid_i && !bypass_ok && over;
  assign enq  = in_valid_i && !bypass_ok && !over && pwr_ok;
  assign deq  = !q_empty && srv_ready_i;
  assign arr  = in_valid_i && in_ready_o;

  assign in_ready_o  = bypass_ok || over || pwr_ok;
  assign srv_valid_o = !q_empty || in_valid_i;
  assign srv_size_o  = q_empty ? in_size_i : head_size;

  // occupancy bookkeeping after this cycle's store and dequeue
  always_comb begin
    logic [31:0] t;
    t = 32'(tot_q);
    if (enq) t = t + 32'(in_size_i);
    if (deq) t = t - 32'(head_size);
    tot_d = TOT_W'(t);
    cnt_d = q_cnt + CW'(enq) - CW'(deq);
  end

  assign live_cur = BW'(banks_of(32'(tot_q), !q_empty, BANK_SH));
  assign live_nxt = BW'(banks_of(32'(tot_d), cnt_d != '0, BANK_SH));
  assign pend     = (in_valid_i && !bypass_ok && !over && !pwr_ok) ? BW'(need_bk) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tot_q  <= '0;
      drop_q <= '0;
    end else begin
      tot_q <= tot_d;
      if (drop && (drop_q != {DROP_W{1'b1}})) drop_q <= drop_q + DROP_W'(1);
    end
  end

  mem_bank_size_fifo #(
    .DEPTH (QUEUE_DEPTH),
    .W     (SIZE_W)
  ) i_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (enq),
    .pop_i  (deq),
    .din_i  (in_size_i),
    .dout_o (head_size),
    .cnt_o  (q_cnt)
  );

  mem_bank_pwr_switch #(
    .NUM_BANKS (NUM_BANKS)
  ) i_switch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .live_cur_i (live_cur),
    .live_nxt_i (live_nxt),
    .pend_i     (pend),
    .on_cnt_o   (on_cnt),
    .en_o       (bank_en_o)
  );

  mem_bank_energy_acc #(
    .COST_W   (COST_W),
    .ENERGY_W (ENERGY_W),
    .BW       (BW)
  ) i_energy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arr_i        (arr),
    .enq_i        (enq),
    .enq_banks_i  (live_nxt),
    .srv_i        (bypass || deq),
    .cost_arr_i   (cost_arr_i),
    .cost_queue_i (cost_queue_i),
    .cost_srv_i   (cost_srv_i),
    .energy_o     (energy_o)
  );

  assign bank_on_cnt_o = on_cnt;
  assign queue_cnt_o   = q_cnt;
  assign drop_cnt_o    = drop_q;

endmodule

// File: rtl/mem_bank_pwr_ctrl_chk.sv
module mem_bank_pwr_ctrl_chk #(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned QUEUE_DEPTH = 100,
  parameter int unsigned SIZE_W      = 16,
  parameter int unsigned ENERGY_W    = 32,
  parameter int unsigned DROP_W      = 16,
  localparam int unsigned BW         = $clog2(NUM_BANKS + 1),
  localparam int unsigned CW         = $clog2(QUEUE_DEPTH + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic                 in_ready_o,
  input logic [SIZE_W-1:0]    in_size_i,
  input logic                 srv_valid_o,
  input logic                 srv_ready_i,
  input logic [SIZE_W-1:0]    srv_size_o,
  input logic [NUM_BANKS-1:0] bank_en_o,
  input logic [BW-1:0]        bank_on_cnt_o,
  input logic [CW-1:0]        queue_cnt_o,
  input logic [DROP_W-1:0]    drop_cnt_o,
  input logic [ENERGY_W-1:0]  energy_o
);

  a_r1_bypass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && srv_ready_i && queue_cnt_o == '0) |->
      (in_ready_o && srv_valid_o && srv_size_o == in_size_i));

  a_r1_bypass_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && srv_ready_i && queue_cnt_o == '0) |=> (queue_cnt_o == '0));

  a_r2_head_offered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (queue_cnt_o != '0) |-> srv_valid_o);

  a_r3_min_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (queue_cnt_o != '0) |-> (bank_on_cnt_o != '0));

  a_r3_thermometer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bank_en_o & (bank_en_o + NUM_BANKS'(1))) == '0) &&
    ($countones(bank_en_o) == int'(bank_on_cnt_o)));

  a_r4_stall_powers_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |=> (bank_on_cnt_o > $past(bank_on_cnt_o)));

  a_r6_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    queue_cnt_o <= CW'(QUEUE_DEPTH));

  a_r6_drop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drop_cnt_o == $past(drop_cnt_o) ||
              drop_cnt_o == $past(drop_cnt_o) + DROP_W'(1)));

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (energy_o >= $past(energy_o)));

endmodule

bind mem_bank_pwr_ctrl mem_bank_pwr_ctrl_chk #(
  .NUM_BANKS   (NUM_BANKS),
  .QUEUE_DEPTH (QUEUE_DEPTH),
  .SIZE_W      (SIZE_W),
  .ENERGY_W    (ENERGY_W),
  .DROP_W      (DROP_W)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .in_size_i     (in_size_i),
  .srv_valid_o   (srv_valid_o),
  .srv_ready_i   (srv_ready_i),
  .srv_size_o    (srv_size_o),
  .bank_en_o     (bank_en_o),
  .bank_on_cnt_o (bank_on_cnt_o),
  .queue_cnt_o   (queue_cnt_o),
  .drop_cnt_o    (drop_cnt_o),
  .energy_o      (energy_o)
);

// File: tb/test_mem_bank_pwr_ctrl.sv
`timescale 1ns/1ps
module test_mem_bank_pwr_ctrl;

  localparam int unsigned NB = 4, BB = 64, QD = 5;
  localparam int unsigned EW = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] in_size_i = '0;
  logic       srv_valid_o;
  logic       srv_ready_i = 1'b0;
  logic [7:0] srv_size_o;
  logic [3:0] bank_en_o;
  logic [2:0] bank_on_cnt_o;
  logic [2:0] queue_cnt_o;
  logic [7:0] drop_cnt_o;
  logic [EW-1:0] energy_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  mem_bank_pwr_ctrl #(
    .NUM_BANKS(NB), .BANK_BYTES(BB), .QUEUE_DEPTH(QD), .SIZE_W(8),
    .COST_W(8), .ENERGY_W(EW), .DROP_W(8)
  ) i_mem_bank_pwr_ctrl (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_size_i,
    .srv_valid_o, .srv_ready_i, .srv_size_o,
    .cost_arr_i(8'd3), .cost_queue_i(8'd2), .cost_srv_i(8'd5),
    .bank_en_o, .bank_on_cnt_o, .queue_cnt_o, .drop_cnt_o, .energy_o
  );

  typedef struct packed {
    logic       v;
    logic [7:0] sz;
    logic       sr;
    logic       e_rdy;
    logic       e_sv;
    logic [7:0] e_ssz;
    logic [3:0] e_cnt;
    logic [3:0] e_on;
  } vec_t;

  // R1 bypass, R2 order, R3 bank count, R4 power-up stall, R5 lagged switch-off
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'd10,  1'b1, 1'b1, 1'b1, 8'd10,  4'd0, 4'd0},
    '{1'b1, 8'd100, 1'b0, 1'b0, 1'b1, 8'd100, 4'd0, 4'd2},
    '{1'b1, 8'd100, 1'b0, 1'b1, 1'b1, 8'd100, 4'd1, 4'd2},
    '{1'b1, 8'd20,  1'b0, 1'b1, 1'b1, 8'd100, 4'd2, 4'd2},
    '{1'b1, 8'd30,  1'b0, 1'b0, 1'b1, 8'd100, 4'd2, 4'd3},
    '{1'b1, 8'd30,  1'b0, 1'b1, 1'b1, 8'd100, 4'd3, 4'd3},
    '{1'b0, 8'd0,   1'b1, 1'b0, 1'b1, 8'd100, 4'd2, 4'd3},
    '{1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 8'd20,  4'd2, 4'd1},
    '{1'b1, 8'd5,   1'b1, 1'b1, 1'b1, 8'd20,  4'd2, 4'd1},
    '{1'b0, 8'd0,   1'b1, 1'b0, 1'b1, 8'd30,  4'd1, 4'd1},
    '{1'b0, 8'd0,   1'b1, 1'b0, 1'b1, 8'd5,   4'd0, 4'd1},
    '{1'b0, 8'd0,   1'b0, 1'b0, 1'b0, 8'd0,   4'd0, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid_i = 1'b0; srv_ready_i = 1'b0; in_size_i = '0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // called at a negedge; holds the packet until accepted, returns at a negedge
  task automatic send(input logic [7:0] sz, input logic sr);
    in_valid_i = 1'b1; in_size_i = sz; srv_ready_i = sr;
    #1;
    while (!in_ready_o) begin
      @(negedge clk_i); #1;
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 queue", 32'(queue_cnt_o), 0);
    chk("R9 banks", 32'(bank_en_o), 0);
    chk("R9 drops", 32'(drop_cnt_o), 0);
    chk("R9 energy", 32'(energy_o), 0);

    for (int i = 0; i < NV; i++) begin
      in_valid_i = VEC[i].v; in_size_i = VEC[i].sz; srv_ready_i = VEC[i].sr;
      #1;
      if (VEC[i].v) chk($sformatf("R4 ready step%0d", i), 32'(in_ready_o), 32'(VEC[i].e_rdy));
      chk($sformatf("R2 srv_valid step%0d", i), 32'(srv_valid_o), 32'(VEC[i].e_sv));
      if (VEC[i].e_sv) chk($sformatf("R1 srv_size step%0d", i), 32'(srv_size_o), 32'(VEC[i].e_ssz));
      @(negedge clk_i);
      chk($sformatf("R2 qcnt step%0d", i), 32'(queue_cnt_o), 32'(VEC[i].e_cnt));
      chk($sformatf("R5 banks step%0d", i), 32'(bank_on_cnt_o), 32'(VEC[i].e_on));
      chk($sformatf("R3 enables step%0d", i), 32'(bank_en_o), (32'd1 << VEC[i].e_on) - 1);
    end
    in_valid_i = 1'b0; srv_ready_i = 1'b0;
    chk("R7 energy after table", 32'(energy_o), 56);

    // R6 depth-full drop
    do_reset();
    for (int k = 0; k < 5; k++) send(8'd1, 1'b0);
    chk("R6 full count", 32'(queue_cnt_o), 5);
    chk("R3 one bank", 32'(bank_on_cnt_o), 1);
    in_valid_i = 1'b1; in_size_i = 8'd1; srv_ready_i = 1'b0;
    #1 chk("R6 drop ready", 32'(in_ready_o), 1);
    @(negedge clk_i); in_valid_i = 1'b0;
    chk("R6 drop counted", 32'(drop_cnt_o), 1);
    chk("R6 queue kept", 32'(queue_cnt_o), 5);
    chk("R7 energy drop", 32'(energy_o), 28);

    // R6 byte-capacity drop
    do_reset();
    send(8'd200, 1'b0);
    chk("R4 four banks", 32'(bank_on_cnt_o), 4);
    in_valid_i = 1'b1; in_size_i = 8'd100;
    #1 chk("R6 overflow ready", 32'(in_ready_o), 1);
    @(negedge clk_i); in_valid_i = 1'b0;
    chk("R6 overflow dropped", 32'(drop_cnt_o), 1);
    chk("R6 overflow queue", 32'(queue_cnt_o), 1);
    chk("R6 overflow banks", 32'(bank_on_cnt_o), 4);

    // R8 saturation with back-to-back bypass
    do_reset();
    in_valid_i = 1'b1; in_size_i = 8'd1; srv_ready_i = 1'b1;
    repeat (10) @(negedge clk_i);
    chk("R7 bypass energy", 32'(energy_o), 80);
    chk("R1 bypass banks off", 32'(bank_on_cnt_o), 0);
    repeat (520) @(negedge clk_i);
    chk("R8 saturated", 32'(energy_o), 4095);
    repeat (3) @(negedge clk_i);
    chk("R8 held", 32'(energy_o), 4095);
    in_valid_i = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule